// File: doc/BRIEF.md
# Peripheral Read Cycle Sequencer

This block runs one read cycle on a legacy-style parallel peripheral bus that has its own I/O address space. A local requester gives it a 16-bit I/O address. The block then steps through a fixed series of clock states: C1, C2, an optional stretch of wait states, C3 and C4. While it does so, it drives the address latch enable, the active-low I/O read strobe and the address lines. It also samples the 8-bit data lines. The byte it reads comes back to the requester together with a one-cycle completion pulse.

The addressed device slows the cycle by holding its ready line low. Each low sample adds one more wait state between C2 and C3. If the device keeps the line low for more than a parameterised number of wait states, the block gives up on the cycle. It releases the strobe and raises an error pulse in place of the completion pulse. This block produces only I/O reads. It does not drive memory strobes or I/O write strobes, and it does not request ownership of the bus.

Top module: `io_rd_cycle`

## Requirements
- R1: While reset is held and just after it is released, `bus_ale_o` and `done_o` and `err_o` are 0, and `bus_ior_no` is 1.
- R2: A `req_i` sampled high while the block is idle starts a cycle. `bus_ale_o` is 1 in the next cycle (C1) and for that single cycle only.
- R3: `bus_ior_no` is 0 for C2, each wait state and C3, so for 2+N cycles when the device asks for N wait states. It is 1 in C1 and in C4.
- R4: From C1 through C4, `bus_addr_o` carries the address that was sampled with the accepted request and does not change. It is therefore stable for at least one cycle before the read strobe falls.
- R5: `bus_rdy_i` is sampled at the end of C2 and at the end of each wait state. A low sample adds or keeps a wait state, and a high sample moves the cycle on to C3.
- R6: `done_o` is 1 for exactly the C4 cycle of a completed read. During that cycle, `data_o` holds the value that `bus_data_i` had at the end of C3.
- R7: If `bus_rdy_i` is still low at the end of the MAX_WAIT-th wait state, the cycle goes to C4 with the strobe released. `err_o` is 1 for that cycle and `done_o` stays 0. A device that needs exactly MAX_WAIT wait states still completes normally.
- R8: `req_i` and `addr_i` are ignored while a cycle is in progress. No second ALE pulse appears and the bus address does not change until the cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a read cycle (taken when idle) |
| addr_i | input | 16 | I/O address to read |
| data_o | output | 8 | Byte returned, valid while done_o is 1 |
| done_o | output | 1 | Completion pulse (C4 of a good read) |
| err_o | output | 1 | Timeout pulse (C4 of an aborted read) |
| bus_ale_o | output | 1 | Address latch enable, high in C1 |
| bus_ior_no | output | 1 | I/O read strobe, active low |
| bus_addr_o | output | 16 | Bus address lines |
| bus_data_i | input | 8 | Bus data lines |
| bus_rdy_i | input | 1 | Device ready; low requests a wait state |

## Verification
Some properties are checked by assertions on every cycle:
- ALE is a single-cycle pulse.
- The strobe falls only right after ALE.
- The address is steady while the strobe is low.
- A low ready sample below the limit keeps the cycle in a wait state, and a high sample in C2 goes straight to C3.
- Completion follows C3, and completion and error never occur together.

Other behaviours can only be shown by the bench scenarios, which use a device model with a configurable ready delay. These are the exact strobe length for a given number of wait states, the returned byte, the boundary between MAX_WAIT and MAX_WAIT+1 wait states, and the fact that requests made during a cycle are ignored.

// File: rtl/io_rd_pkg.sv
package io_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_C1,
    ST_C2,
    ST_WAIT,
    ST_C3,
    ST_C4
  } cyc_state_e;
endpackage

// File: rtl/io_rd_wait_cnt.sv
module io_rd_wait_cnt #(
  parameter int MAX_WAIT = 8,
  localparam int CntW = $clog2(MAX_WAIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic step_i,
  output logic at_limit_o
);
  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= CntW'(1);
    else if (step_i)  cnt_q <= cnt_q + CntW'(1);
  end

  assign at_limit_o = (cnt_q == CntW'(MAX_WAIT));

  p_cnt_bounded_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i) |-> (cnt_q < CntW'(MAX_WAIT)));
endmodule

// File: rtl/io_rd_seq.sv
module io_rd_seq
  import io_rd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       rdy_i,
  input  logic       at_limit_i,
  output cyc_state_e state_o,
  output logic       abort_o,
  output logic       accept_o,
  output logic       wait_start_o,
  output logic       wait_step_o
);
  cyc_state_e state_q, state_d;
  logic       abort_q;
  logic       timeout;

  assign timeout = (state_q == ST_WAIT) && !rdy_i && at_limit_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_C1;
      ST_C1:   state_d = ST_C2;
      ST_C2:   state_d = rdy_i ? ST_C3 : ST_WAIT;
      ST_WAIT: begin
        if (rdy_i)        state_d = ST_C3;
        else if (timeout) state_d = ST_C4;
      end
      ST_C3:   state_d = ST_C4;
      ST_C4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (timeout)                abort_q <= 1'b1;
      else if (state_q == ST_C4)  abort_q <= 1'b0;
    end
  end

  assign state_o      = state_q;
  assign abort_o      = abort_q;
  assign accept_o     = (state_q == ST_IDLE) && req_i;
  assign wait_start_o = (state_q == ST_C2) && !rdy_i;
  assign wait_step_o  = (state_q == ST_WAIT) && !rdy_i && !at_limit_i;

  p_wait_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !rdy_i && !at_limit_i) |=> (state_q == ST_WAIT));
  p_ready_skips_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_C2 && rdy_i) |=> (state_q == ST_C3));
  p_timeout_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout |=> (state_q == ST_C4 && abort_q));
endmodule

// File: rtl/io_rd_latch.sv
module io_rd_latch #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          data_load_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
    end else begin
      if (addr_load_i) addr_o <= addr_i;
      if (data_load_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/io_rd_cycle.sv
module io_rd_cycle
  import io_rd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int MAX_WAIT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o,
  output logic          done_o,
  output logic          err_o,
  output logic          bus_ale_o,
  output logic          bus_ior_no,
  output logic [AW-1:0] bus_addr_o,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_rdy_i
);
  cyc_state_e state;
  logic       abort, accept, wait_start, wait_step, at_limit;

  io_rd_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .rdy_i       (bus_rdy_i),
    .at_limit_i  (at_limit),
    .state_o     (state),
    .abort_o     (abort),
    .accept_o    (accept),
    .wait_start_o(wait_start),
    .wait_step_o (wait_step)
  );

  io_rd_wait_cnt #(.MAX_WAIT(MAX_WAIT)) u_wcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (wait_start),
    .step_i    (wait_step),
    .at_limit_o(at_limit)
  );

  io_rd_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_load_i(accept),
    .addr_i     (addr_i),
    .data_load_i(state == ST_C3),
    .data_i     (bus_data_i),
    .addr_o     (bus_addr_o),
    .data_o     (data_o)
  );

  assign bus_ale_o  = (state == ST_C1);
  assign bus_ior_no = !(state == ST_C2 || state == ST_WAIT || state == ST_C3);
  assign done_o     = (state == ST_C4) && !abort;
  assign err_o      = (state == ST_C4) && abort;

  p_ale_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |=> !bus_ale_o);
  p_strobe_after_ale_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_ior_no) |-> $past(bus_ale_o));
  p_addr_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ior_no || bus_ale_o) |=> (bus_ale_o || $stable(bus_addr_o)));
  p_done_err_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  p_done_after_c3_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state == ST_C3));
  p_no_ale_in_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ior_no) |-> !bus_ale_o);
endmodule

// File: tb/test_io_rd_cycle.sv
module test_io_rd_cycle;
  localparam int MAX_WAIT = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_o;
  logic        done_o, err_o, bus_ale_o, bus_ior_no;
  logic [15:0] bus_addr_o;
  logic [7:0]  bus_data_i;
  logic        bus_rdy_i;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  int       dev_dly  = 0;
  logic [7:0] dev_byte = 8'h00;
  int       low_cnt  = 0;

  always #2 clk = ~clk;

  io_rd_cycle #(.MAX_WAIT(MAX_WAIT)) i_io_rd_cycle (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .data_o(data_o), .done_o(done_o), .err_o(err_o),
    .bus_ale_o(bus_ale_o), .bus_ior_no(bus_ior_no), .bus_addr_o(bus_addr_o),
    .bus_data_i(bus_data_i), .bus_rdy_i(bus_rdy_i)
  );

  // device model: ready after dev_dly wait states, data driven only when ready
  always_ff @(posedge clk) begin
    if (bus_ior_no) low_cnt <= 0;
    else            low_cnt <= low_cnt + 1;
  end
  assign bus_rdy_i  = (low_cnt >= dev_dly);
  assign bus_data_i = (!bus_ior_no && bus_rdy_i) ? dev_byte : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one read; hold_req keeps req_i high with a changing address (R8)
  task automatic run_read(input logic [15:0] a, input int dly, input logic [7:0] b,
                          input bit hold_req);
    int ale_n = 0, low_n = 0, n = 0;
    bit addr_bad = 0, got_done = 0, got_err = 0;
    logic [7:0] got = 8'h00;
    dev_dly  = dly;
    dev_byte = b;
    @(negedge clk);
    req_i  = 1'b1;
    addr_i = a;
    @(negedge clk);
    check(bus_ale_o == 1'b1 && bus_ior_no == 1'b1, "R2", bus_ale_o, 1);
    if (!hold_req) req_i = 1'b0;
    while (!(done_o || err_o) && n < 100) begin
      if (hold_req) addr_i = addr_i + 16'h0101;
      if (bus_ale_o) ale_n++;
      if (!bus_ior_no) low_n++;
      if (bus_addr_o != a) addr_bad = 1;
      @(negedge clk);
      n++;
    end
    got_done = done_o;
    got_err  = err_o;
    got      = data_o;
    if (bus_addr_o != a) addr_bad = 1;
    check(bus_ior_no == 1'b1, "R3", bus_ior_no, 1);
    req_i = 1'b0;
    check(ale_n == 1, hold_req ? "R8" : "R2", ale_n, 1);
    check(!addr_bad, hold_req ? "R8" : "R4", addr_bad, 0);
    if (dly <= MAX_WAIT) begin
      check(low_n == 2 + dly, "R3", low_n, 2 + dly);
      check(got_done && !got_err, "R6", {got_done, got_err}, 2'b10);
      check(got == b, "R6", got, b);
    end else begin
      check(low_n == 1 + MAX_WAIT, "R7", low_n, 1 + MAX_WAIT);
      check(got_err && !got_done, "R7", {got_done, got_err}, 2'b01);
    end
    @(negedge clk);
    check(!done_o && !err_o && !bus_ale_o, "R8", {done_o, err_o, bus_ale_o}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!bus_ale_o && bus_ior_no && !done_o && !err_o, "R1",
          {bus_ale_o, bus_ior_no, done_o, err_o}, 4'b0100);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!bus_ale_o && bus_ior_no && !done_o && !err_o, "R1",
          {bus_ale_o, bus_ior_no, done_o, err_o}, 4'b0100);
  endtask

  task automatic t_no_wait();      run_read(16'h0378, 0, 8'hA5, 0); endtask // R3 R6
  task automatic t_some_waits();   run_read(16'h03F8, 3, 8'h5A, 0); endtask // R5
  task automatic t_limit_ok();     run_read(16'hFFFF, MAX_WAIT, 8'h3C, 0); endtask // R7 boundary
  task automatic t_timeout();      run_read(16'h0060, MAX_WAIT + 1, 8'h77, 0); endtask // R7
  task automatic t_after_abort();  run_read(16'h0001, 1, 8'hC3, 0); endtask // R6
  task automatic t_req_held();     run_read(16'h1234, 2, 8'h81, 1); endtask // R8

  initial begin
    t_reset();
    t_no_wait();
    t_some_waits();
    t_limit_ok();
    t_timeout();
    t_after_abort();
    t_req_held();
    finish_run();
  end

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 20000);
    finish_run();
  end
endmodule